// File: doc/BRIEF.md
# Synthesizer Divider Configuration Capture

This block holds the settings that steer a clock synthesizer: a 9-bit feedback divide value M, a 2-bit output-divider select N and a spread-spectrum enable. Two independent load paths can write them. A parallel path takes M from nine input pins under an active-low parallel-load strobe. A three-wire serial path shifts a frame in on a serial clock and commits it under a serial load strobe. Each strobe has a transparent phase, in which the outputs follow their source, and a latched phase, in which the outputs hold.

All strobe, clock and data pins are brought into the system clock through two-flop synchronizers. Edges are then found in that domain. An output responds on the third system clock edge after its input pin changes.

The serial frame is 14 bits long and sent first bit first. It carries two dead slots, the spread-spectrum enable, N1, N0, and then M8 down to M0. The shift register keeps only the last 12 bits, so the dead slots are discarded. A range flag marks any M value the synthesizer could not lock to. The flag never blocks a load.

Top module: `syn_div_cfg`

## Requirements
- R1: After the asynchronous power-up reset, with the parallel strobe held high, m_out equals M_RESET (default 200), n_sel is 2'b01 and ssc_en is 0.
- R2: While par_load_n is low, m_out follows par_m and n_sel is forced to 2'b01 (divide-by-2). The response lands within three system clocks.
- R3: When par_load_n rises, the M value present at that moment is kept, and later changes on par_m have no effect.
- R4: With par_load_n high and ser_load low, shifting a complete frame leaves m_out, n_sel and ssc_en unchanged.
- R5: A rising ser_load (with par_load_n high) copies the last 12 shifted bits to the outputs. The earliest of these bits drives ssc_en, the next two drive n_sel (MSB first), and the last nine drive m_out (MSB first). The two dead slots at the head of the 14-bit frame have no effect.
- R6: After ser_load falls, further serial clock edges do not change the outputs.
- R7: While ser_load is high, each rising ser_clk updates the outputs from the shifted contents. When ser_clk and ser_load rise in the same synchronized cycle, the load includes the newly shifted bit.
- R8: Entering parallel mode forces n_sel to 2'b01 and leaves ssc_en unchanged. After par_load_n rises again, n_sel stays 2'b01 until a serial load.
- R9: A serial load overrides an M value captured from the parallel path.
- R10: m_range_err is high exactly when m_out is below 125 or above 350.
- R11: Serial clock edges that occur while par_load_n is low do not alter the shift register.
- N encoding on n_sel: 00 divide-by-1, 01 divide-by-2, 10 divide-by-4, 11 divide-by-8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| par_m | input | 9 | Parallel M value |
| par_load_n | input | 1 | Active-low parallel-load strobe; low = transparent |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, sampled on ser_clk rise |
| ser_load | input | 1 | Serial load strobe; high = transparent |
| m_out | output | 9 | Feedback divide value M |
| n_sel | output | 2 | Output divider select |
| ssc_en | output | 1 | Spread-spectrum enable |
| m_range_err | output | 1 | M outside the lockable range 125..350 |

## Verification
A rising serial clock and a rising serial load strobe can be seen in the same synchronized cycle. In that case the commit must take the shift result that includes the bit arriving in that cycle, not the older contents. The bench shifts 13 bits of a frame, then raises ser_clk and ser_load together with the 14th bit on ser_data. It expects the outputs to show the complete frame. The bench also keeps the parallel strobe low while serial clocks toggle, and judges after a later commit that the parallel path owned the outputs and the shift register was left untouched.

// File: rtl/syn_div_cfg.sv
`timescale 1ns/1ps
module syn_div_cfg #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter logic [M_W-1:0] M_RESET = 9'd200,
  parameter logic [M_W-1:0] M_MIN   = 9'd125,
  parameter logic [M_W-1:0] M_MAX   = 9'd350,
  parameter logic [N_W-1:0] N_PAR   = 2'b01
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] par_m,
  input  logic           par_load_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_sel,
  output logic           ssc_en,
  output logic           m_range_err
);
  localparam int SSC_POS = M_W + N_W;
  localparam int SH_W    = SSC_POS + 1;
  localparam logic [3:0] SYNC_RST = 4'b1000;

  // synchronizer bit order: {par_load_n, ser_clk, ser_data, ser_load}
  logic [3:0]     s1, s2, s3;
  logic [M_W-1:0] pm1, pm2;
  logic [SH_W-1:0] sh, sh_next;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= SYNC_RST; s2 <= SYNC_RST; s3 <= SYNC_RST;
      pm1 <= '0; pm2 <= '0;
    end else begin
      s1 <= {par_load_n, ser_clk, ser_data, ser_load};
      s2 <= s1; s3 <= s2;
      pm1 <= par_m; pm2 <= pm1;
    end

  wire pl       = s2[3];
  wire sck_rise = s2[2] & ~s3[2];
  wire sd       = s2[1];
  wire sld      = s2[0];
  wire sld_rise = s2[0] & ~s3[0];
  wire load     = pl & sld & (sld_rise | sck_rise);

  assign sh_next = (pl && sck_rise) ? {sh[SH_W-2:0], sd} : sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0; m_out <= M_RESET; n_sel <= N_PAR; ssc_en <= 1'b0;
    end else begin
      sh <= sh_next;
      if (!pl) begin
        m_out <= pm2;
        n_sel <= N_PAR;
      end else if (load) begin
        m_out  <= sh_next[M_W-1:0];
        n_sel  <= sh_next[SSC_POS-1:M_W];
        ssc_en <= sh_next[SSC_POS];
      end
    end

  assign m_range_err = (m_out < M_MIN) || (m_out > M_MAX);

  assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pl |=> (m_out == $past(pm2)));
  assert_par_ndiv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pl |=> (n_sel == N_PAR) && $stable(ssc_en));
  assert_ser_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pl && !sld) |=> $stable(m_out) && $stable(n_sel) && $stable(ssc_en));
  assert_ser_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pl && sld_rise && !sck_rise) |=> (m_out == $past(sh[M_W-1:0])) && (ssc_en == $past(sh[SSC_POS])));
  assert_par_noshift_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pl |=> $stable(sh));
endmodule

// File: tb/tb_syn_div_cfg.sv
`timescale 1ns/1ps
module tb_syn_div_cfg;
  logic clk = 0, rst_n = 0;
  logic [8:0] par_m = 0;
  logic par_load_n = 1, ser_clk = 0, ser_data = 0, ser_load = 0;
  logic [8:0] m_out; logic [1:0] n_sel; logic ssc_en, m_range_err;
  int ntests = 0, nfail = 0;
  logic [11:0] sh_model = 0;
  logic [8:0] em = 9'd200; logic [1:0] en = 2'b01; logic es = 0;

  syn_div_cfg dut (.clk(clk), .rst_n(rst_n), .par_m(par_m), .par_load_n(par_load_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .m_out(m_out), .n_sel(n_sel), .ssc_en(ssc_en), .m_range_err(m_range_err));

  always #2.5 clk = ~clk;

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog expired: actual running, expected finished");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  task automatic waitc(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req);
    logic er;
    er = (em < 9'd125) || (em > 9'd350);
    ntests++;
    if (m_out !== em || n_sel !== en || ssc_en !== es || m_range_err !== er) begin
      nfail++;
      $display("FAIL %s: actual m=%0d n=%b ssc=%b err=%b expected m=%0d n=%b ssc=%b err=%b",
               req, m_out, n_sel, ssc_en, m_range_err, em, en, es, er);
    end
  endtask

  task automatic take_sh();
    em = sh_model[8:0]; en = sh_model[10:9]; es = sh_model[11];
  endtask

  task automatic sbit(logic b);
    ser_data = b; waitc(4);
    ser_clk = 1;
    if (par_load_n) sh_model = {sh_model[10:0], b};
    if (par_load_n && ser_load) take_sh();
    waitc(4);
    ser_clk = 0; waitc(4);
  endtask

  task automatic sframe(logic [1:0] d, logic s, logic [1:0] n, logic [8:0] m);
    logic [13:0] f;
    f = {d, s, n, m};
    for (int i = 13; i >= 0; i--) sbit(f[i]);
  endtask

  task automatic spulse();
    ser_load = 1;
    if (par_load_n) take_sh();
    waitc(5);
    ser_load = 0; waitc(5);
  endtask

  initial begin
    waitc(5); rst_n = 1; waitc(5);
    chk("R1 reset");

    par_load_n = 0;
    for (int v = 0; v < 512; v++) begin
      par_m = 9'(v); em = 9'(v); en = 2'b01;
      waitc(4);
      chk("R2 R10 parallel transparent");
    end

    par_m = 9'd300; em = 9'd300; waitc(4);
    par_load_n = 1; waitc(5);
    par_m = 9'd17; waitc(5);
    chk("R3 parallel capture");

    sframe(2'b11, 1'b0, 2'b10, 9'd180);
    chk("R4 shift without load");
    spulse();
    chk("R9 serial overrides parallel");

    for (int n = 0; n < 4; n++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 5; k++) begin
          sframe(2'(k), 1'(s), 2'(n), 9'((k*97 + n*31 + s*7 + 11) % 512));
          chk("R4 frame shifted, outputs held");
          spulse();
          chk("R5 serial commit");
        end

    sframe(2'b00, 1'b0, 2'b00, 9'd124); spulse(); chk("R10 M=124");
    sframe(2'b01, 1'b0, 2'b00, 9'd125); spulse(); chk("R10 M=125");
    sframe(2'b10, 1'b0, 2'b00, 9'd350); spulse(); chk("R10 M=350");
    sframe(2'b11, 1'b0, 2'b00, 9'd351); spulse(); chk("R10 M=351");

    sframe(2'b00, 1'b1, 2'b11, 9'd222); spulse();
    chk("R5 commit 222");
    sframe(2'b00, 1'b0, 2'b00, 9'd40);
    chk("R6 latched after load falls");

    sframe(2'b00, 1'b1, 2'b11, 9'd222); spulse();
    par_load_n = 0; par_m = 9'd150; em = 9'd150; en = 2'b01; waitc(5);
    chk("R8 parallel forces divide-by-2");
    par_load_n = 1; waitc(5);
    chk("R8 N stays divide-by-2 after parallel");

    sframe(2'b10, 1'b0, 2'b10, 9'd260);
    par_load_n = 0; par_m = 9'd199; em = 9'd199; waitc(5);
    sframe(2'b01, 1'b1, 2'b01, 9'd5);
    chk("R11 parallel owns outputs");
    par_load_n = 1; waitc(5);
    spulse();
    chk("R11 shift register untouched in parallel mode");

    ser_load = 1; take_sh(); waitc(5);
    begin
      logic [13:0] f;
      f = {2'b00, 1'b1, 2'b00, 9'd333};
      for (int i = 13; i >= 0; i--) begin
        sbit(f[i]);
        chk("R7 transparent serial update");
      end
    end
    ser_load = 0; waitc(5);

    begin
      logic [13:0] f;
      f = {2'b11, 1'b0, 2'b11, 9'd257};
      for (int i = 13; i >= 1; i--) sbit(f[i]);
      chk("R4 before same-cycle load");
      ser_data = f[0]; waitc(4);
      ser_clk = 1; ser_load = 1;
      sh_model = {sh_model[10:0], f[0]}; take_sh();
      waitc(5);
      chk("R7 clock and load same cycle");
      ser_clk = 0; ser_load = 0; waitc(5);
    end

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule